// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes configuration words over a three-wire serial port (serial clock, strobe, data) and places them in the registers that steer a frequency synthesizer. While the strobe is low, every rising edge of the serial clock shifts one data bit in, most significant bit first. The rising edge of the strobe closes the word. The number of bits clocked in gives the word length, and the address bits give the word's destination. The serial pins are oversampled by the block's own clock through synchronizers, so the serial clock must be several times slower than the system clock.

The main-divider word is double buffered. Once received, it waits as a single pending entry until the main divider raises its synchronization input. Only then does it move, together with the staged charge-pump fields, into the working registers. This keeps the divider from being reprogrammed partway through a count. A control word selects between a short and a long main-divider format. A separate test word is wiped whenever a control word is written. A speed-up flag marks the time after a main-divider word during which the strobe is still high.

Top module: `synth_serial_prog`

## Requirements
- R1: While the strobe is low, each rising serial-clock edge shifts the data pin into the word, MSB first. While the strobe is high, serial-clock edges are ignored and add no bits.
- R2: A word ends on the strobe rising edge. Only words of exactly 24 or 32 clocked bits are accepted. Any other count leaves every register unchanged.
- R3: A 32-bit word is routed by bits [3:0]: 1 = long main word, 2 = staging word, 3 = aux word, 4 = control word, 5 = test word. Other codes are discarded. A 24-bit word is a short main word when bit 0 is 0 and is discarded when bit 0 is 1.
- R4: A control word loads `long_fmt` from bit 31 and `ctl_cfg` from bits [30:4], and clears `test_cfg` to zero.
- R5: An aux word loads `aux_cfg` from bits [31:4]. A test word loads `test_cfg` from bits [31:4].
- R6: A staging word stores a count value (bits [31:24]) and a pump-range value (bits [23:22]) in temporary registers. It has no effect on `main_cn` or `main_pr` until a main word commits.
- R7: With `long_fmt`=0, only short main words are accepted, and the divider value is bits [23:4]. With `long_fmt`=1, only long main words are accepted, with the divider value in bits [31:12] and the count in bits [11:4]. A main word of the other format is discarded.
- R8: A received main word commits at the first clock edge where `div_sync` is high. At commit, `main_div` takes the word's divider value, `main_pr` takes the staged pump range, and `main_cn` takes the word's count (long format) or the staged count as it stands at commit (short format). A `div_sync` pulse with nothing pending changes nothing.
- R9: Only one main word can be pending. A newer main word replaces an uncommitted older one.
- R10: `speedup` rises after a main word is accepted, holds while the strobe stays high, and clears once the strobe goes low.
- R11: Reset clears every register, the temporary registers and the pending entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock |
| ser_strobe | input | 1 | Serial strobe; low enables shifting, rising edge ends a word |
| ser_data | input | 1 | Serial data |
| div_sync | input | 1 | Main-divider synchronization; high permits the main word commit |
| main_div | output | 20 | Working main-divider value |
| main_cn | output | 8 | Working count value |
| main_pr | output | 2 | Working pump-range value |
| aux_cfg | output | 28 | Aux word field |
| ctl_cfg | output | 27 | Control word field |
| long_fmt | output | 1 | Main word format select from the control word |
| test_cfg | output | 28 | Test word field |
| speedup | output | 1 | Charge-pump speed-up flag |

## Verification
The length check is swept over every bit count from 20 to 34 using one test-word pattern. This shows that acceptance depends on the count and not on the address bits left in the shift register. Main words are sent in both formats, both in the matching mode and in the wrong mode, with `div_sync` held low and then pulsed. This separates words received from words committed, and direct counts from staged counts. A staging word written between reception and commit, a replaced pending word, serial clocks sent with the strobe high, and a reset while a word is pending each target one ordering rule.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  localparam int LONG_BITS  = 32;
  localparam int SHORT_BITS = 24;
  localparam int CNT_W      = 6;
  localparam int DIV_W      = 20;
  localparam int CN_W       = 8;
  localparam int PR_W       = 2;
  localparam int CFG_W      = 28;
  localparam int CTL_W      = 27;

  typedef enum logic [3:0] {
    KIND_MAIN  = 4'd1,
    KIND_STAGE = 4'd2,
    KIND_AUX   = 4'd3,
    KIND_CTL   = 4'd4,
    KIND_TEST  = 4'd5
  } word_kind_e;
endpackage

// File: rtl/sprog_rst_sync.sv
module sprog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], din};
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sprog_shifter.sv
module sprog_shifter
  import sprog_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 strobe,
  input  logic                 sdata,
  output logic                 word_done,
  output logic [LONG_BITS-1:0] word,
  output logic [CNT_W-1:0]     nbits
);
  logic                 sclk_d, strobe_d;
  logic [LONG_BITS-1:0] sr_q, sr_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic                 shift_en, end_word;

  assign shift_en = sclk & ~sclk_d & ~strobe;
  assign end_word = strobe & ~strobe_d;

  always_comb begin
    sr_n  = sr_q;
    cnt_n = cnt_q;
    if (shift_en) begin
      sr_n = {sr_q[LONG_BITS-2:0], sdata};
      if (cnt_q != '1) cnt_n = cnt_q + 1'b1;
    end
    if (end_word) cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      strobe_d <= 1'b0;
      sr_q     <= '0;
      cnt_q    <= '0;
    end else begin
      sclk_d   <= sclk;
      strobe_d <= strobe;
      if (shift_en) sr_q <= sr_n;
      if (shift_en || end_word) cnt_q <= cnt_n;
    end
  end

  assign word_done = end_word;
  assign word      = sr_q;
  assign nbits     = cnt_q;
endmodule

// File: rtl/sprog_router.sv
module sprog_router
  import sprog_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe,
  input  logic                 word_done,
  input  logic [LONG_BITS-1:0] word,
  input  logic [CNT_W-1:0]     nbits,
  input  logic                 div_sync,
  output logic [DIV_W-1:0]     main_div,
  output logic [CN_W-1:0]      main_cn,
  output logic [PR_W-1:0]      main_pr,
  output logic [CFG_W-1:0]     aux_cfg,
  output logic [CTL_W-1:0]     ctl_cfg,
  output logic                 long_fmt,
  output logic [CFG_W-1:0]     test_cfg,
  output logic                 speedup
);
  logic             is_short, is_long;
  logic             take_short, take_long, take_stage, take_aux, take_ctl, take_test;
  logic             commit;
  logic             unused_bits;

  logic             pend_q, pend_n;
  logic             pend_long_q, pend_long_n;
  logic [DIV_W-1:0] pend_div_q, pend_div_n;
  logic [CN_W-1:0]  pend_cn_q, pend_cn_n;
  logic [CN_W-1:0]  cn_tmp_q;
  logic [PR_W-1:0]  pr_tmp_q;
  logic             spd_n;

  assign is_short    = word_done && (nbits == CNT_W'(SHORT_BITS));
  assign is_long     = word_done && (nbits == CNT_W'(LONG_BITS));
  assign unused_bits = ^{word[21:4], word[3:1]};

  always_comb begin
    take_stage = 1'b0;
    take_aux   = 1'b0;
    take_ctl   = 1'b0;
    take_test  = 1'b0;
    take_long  = 1'b0;
    take_short = is_short && !word[0] && !long_fmt;
    if (is_long) begin
      case (word_kind_e'(word[3:0]))
        KIND_MAIN:  take_long  = long_fmt;
        KIND_STAGE: take_stage = 1'b1;
        KIND_AUX:   take_aux   = 1'b1;
        KIND_CTL:   take_ctl   = 1'b1;
        KIND_TEST:  take_test  = 1'b1;
        default:    ;
      endcase
    end
  end

  assign commit = pend_q && div_sync;

  always_comb begin
    pend_n      = pend_q;
    pend_long_n = pend_long_q;
    pend_div_n  = pend_div_q;
    pend_cn_n   = pend_cn_q;
    if (commit) pend_n = 1'b0;
    if (take_short) begin
      pend_n      = 1'b1;
      pend_long_n = 1'b0;
      pend_div_n  = word[23:4];
    end
    if (take_long) begin
      pend_n      = 1'b1;
      pend_long_n = 1'b1;
      pend_div_n  = word[31:12];
      pend_cn_n   = word[11:4];
    end
    spd_n = speedup;
    if (!strobe) spd_n = 1'b0;
    if (take_short || take_long) spd_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_long_q <= 1'b0;
      pend_div_q  <= '0;
      pend_cn_q   <= '0;
      cn_tmp_q    <= '0;
      pr_tmp_q    <= '0;
      main_div    <= '0;
      main_cn     <= '0;
      main_pr     <= '0;
      aux_cfg     <= '0;
      ctl_cfg     <= '0;
      long_fmt    <= 1'b0;
      test_cfg    <= '0;
      speedup     <= 1'b0;
    end else begin
      pend_q      <= pend_n;
      pend_long_q <= pend_long_n;
      pend_div_q  <= pend_div_n;
      pend_cn_q   <= pend_cn_n;
      speedup     <= spd_n;
      if (take_stage) begin
        cn_tmp_q <= word[31:24];
        pr_tmp_q <= word[23:22];
      end
      if (commit) begin
        main_div <= pend_div_q;
        main_cn  <= pend_long_q ? pend_cn_q : cn_tmp_q;
        main_pr  <= pr_tmp_q;
      end
      if (take_aux) aux_cfg <= word[31:4];
      if (take_ctl) begin
        long_fmt <= word[31];
        ctl_cfg  <= word[30:4];
      end
      if (take_ctl)       test_cfg <= '0;
      else if (take_test) test_cfg <= word[31:4];
    end
  end
endmodule

// File: rtl/synth_serial_prog.sv
module synth_serial_prog
  import sprog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_strobe,
  input  logic             ser_data,
  input  logic             div_sync,
  output logic [DIV_W-1:0] main_div,
  output logic [CN_W-1:0]  main_cn,
  output logic [PR_W-1:0]  main_pr,
  output logic [CFG_W-1:0] aux_cfg,
  output logic [CTL_W-1:0] ctl_cfg,
  output logic             long_fmt,
  output logic [CFG_W-1:0] test_cfg,
  output logic             speedup
);
  logic                 rst_q_n;
  logic [2:0]           pins_s;
  logic                 strobe_s;
  logic                 word_done;
  logic [LONG_BITS-1:0] word;
  logic [CNT_W-1:0]     nbits;

  sprog_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  sprog_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q_n),
    .din({ser_clk, ser_strobe, ser_data}), .dout(pins_s)
  );

  assign strobe_s = pins_s[1];

  sprog_shifter u_shift (
    .clk(clk), .rst_n(rst_q_n),
    .sclk(pins_s[2]), .strobe(strobe_s), .sdata(pins_s[0]),
    .word_done(word_done), .word(word), .nbits(nbits)
  );

  sprog_router u_route (
    .clk(clk), .rst_n(rst_q_n), .strobe(strobe_s),
    .word_done(word_done), .word(word), .nbits(nbits), .div_sync(div_sync),
    .main_div(main_div), .main_cn(main_cn), .main_pr(main_pr),
    .aux_cfg(aux_cfg), .ctl_cfg(ctl_cfg), .long_fmt(long_fmt),
    .test_cfg(test_cfg), .speedup(speedup)
  );
endmodule

// File: rtl/synth_serial_prog_chk.sv
module synth_serial_prog_chk
  import sprog_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             strobe_s,
  input logic             word_done,
  input logic [CNT_W-1:0] nbits,
  input logic             div_sync,
  input logic [DIV_W-1:0] main_div,
  input logic [CN_W-1:0]  main_cn,
  input logic [PR_W-1:0]  main_pr,
  input logic [CFG_W-1:0] aux_cfg,
  input logic [CTL_W-1:0] ctl_cfg,
  input logic             long_fmt,
  input logic [CFG_W-1:0] test_cfg,
  input logic             speedup
);
  assert_bad_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && nbits != CNT_W'(SHORT_BITS) && nbits != CNT_W'(LONG_BITS))
    |=> ($stable(aux_cfg) && $stable(ctl_cfg) && $stable(long_fmt) && $stable(test_cfg)));

  assert_ctl_clears_test_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ctl_cfg) || !$stable(long_fmt)) |-> (test_cfg == '0));

  assert_commit_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(main_div) || !$stable(main_cn) || !$stable(main_pr)) |-> $past(div_sync));

  assert_speedup_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(speedup) |-> strobe_s);

  assert_speedup_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_s |=> !speedup);
endmodule

bind synth_serial_prog synth_serial_prog_chk i_chk (
  .clk(clk), .rst_n(rst_n), .strobe_s(strobe_s), .word_done(word_done),
  .nbits(nbits), .div_sync(div_sync), .main_div(main_div), .main_cn(main_cn),
  .main_pr(main_pr), .aux_cfg(aux_cfg), .ctl_cfg(ctl_cfg), .long_fmt(long_fmt),
  .test_cfg(test_cfg), .speedup(speedup)
);

// File: tb/test_synth_serial_prog.sv
`timescale 1ns/1ps
module test_synth_serial_prog;
  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_strobe, ser_data, div_sync;
  logic [19:0] main_div;
  logic [7:0]  main_cn;
  logic [1:0]  main_pr;
  logic [27:0] aux_cfg, test_cfg;
  logic [26:0] ctl_cfg;
  logic        long_fmt, speedup;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [19:0] e_div;
  logic [7:0]  e_cn, t_cn;
  logic [1:0]  e_pr, t_pr;
  logic [27:0] e_aux, e_test;
  logic [26:0] e_ctl;
  logic        e_long;

  always #2.5 clk = ~clk;

  synth_serial_prog i_synth_serial_prog (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_strobe(ser_strobe),
    .ser_data(ser_data), .div_sync(div_sync), .main_div(main_div),
    .main_cn(main_cn), .main_pr(main_pr), .aux_cfg(aux_cfg), .ctl_cfg(ctl_cfg),
    .long_fmt(long_fmt), .test_cfg(test_cfg), .speedup(speedup)
  );

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " main_div"}, 32'(main_div), 32'(e_div));
    chk({req, " main_cn"},  32'(main_cn),  32'(e_cn));
    chk({req, " main_pr"},  32'(main_pr),  32'(e_pr));
    chk({req, " aux_cfg"},  32'(aux_cfg),  32'(e_aux));
    chk({req, " ctl_cfg"},  32'(ctl_cfg),  32'(e_ctl));
    chk({req, " long_fmt"}, 32'(long_fmt), 32'(e_long));
    chk({req, " test_cfg"}, 32'(test_cfg), 32'(e_test));
  endtask

  // Shift the low n bits of w, MSB first, then raise the strobe.
  task automatic send(input logic [63:0] w, input int n);
    ser_strobe = 1'b0;
    waitc(4);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      waitc(4);
      ser_clk = 1'b1;
      waitc(4);
      ser_clk = 1'b0;
    end
    waitc(4);
    ser_strobe = 1'b1;
    waitc(10);
  endtask

  task automatic drop_strobe();
    ser_strobe = 1'b0;
    waitc(10);
  endtask

  task automatic pulse_sync();
    div_sync = 1'b1;
    waitc(1);
    div_sync = 1'b0;
    waitc(3);
  endtask

  function automatic logic [63:0] w_ctl(input logic lf, input logic [26:0] c);
    return 64'({lf, c, 4'h4});
  endfunction
  function automatic logic [63:0] w_main_l(input logic [19:0] d, input logic [7:0] c);
    return 64'({d, c, 4'h1});
  endfunction
  function automatic logic [63:0] w_main_s(input logic [19:0] d);
    return 64'({d, 4'h0});
  endfunction
  function automatic logic [63:0] w_stage(input logic [7:0] c, input logic [1:0] p);
    return 64'({c, p, 18'h2A5A5, 4'h2});
  endfunction

  task automatic clear_exp();
    e_div = '0; e_cn = '0; e_pr = '0; e_aux = '0; e_ctl = '0; e_long = 1'b0;
    e_test = '0; t_cn = '0; t_pr = '0;
  endtask

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_strobe = 1'b1; ser_data = 1'b0; div_sync = 1'b0;
    clear_exp();
    waitc(5);
    rst_n = 1'b1;
    waitc(10);
    chk_all("R11 reset");
    chk("R10 reset speedup", 32'(speedup), 32'd0);

    // R4: control word, long format
    send(w_ctl(1'b1, 27'h5A3C0F1), 32);
    e_long = 1'b1; e_ctl = 27'h5A3C0F1;
    chk_all("R4 ctl");

    // R5: test and aux words
    send(64'({28'hBEEF123, 4'h5}), 32);
    e_test = 28'hBEEF123;
    send(64'({28'h7654321, 4'h3}), 32);
    e_aux = 28'h7654321;
    chk_all("R5 test/aux");

    // R3: unknown code and 24-bit word with bit0=1 discarded
    send(64'({28'hFFFFFFF, 4'h9}), 32);
    send(64'({23'h7FFFFF, 1'b1}), 24);
    chk_all("R3 bad code");

    // R2: length sweep with a test-word pattern
    for (int n = 20; n <= 34; n++) begin
      logic [31:0] v;
      v = {28'h0A5C3E1 + 28'(n), 4'h5};
      send({30'h3FFFFFFF, 2'b11, v}, n);
      if (n == 32) e_test = v[31:4];
      chk(n == 32 ? "R2 len 32 accepted" : "R2 len discarded", 32'(test_cfg), 32'(e_test));
    end

    // R1: serial clocks while strobe is high must add no bits
    for (int i = 0; i < 5; i++) begin
      ser_data = 1'b1; waitc(4); ser_clk = 1'b1; waitc(4); ser_clk = 1'b0;
    end
    send(64'({28'h1357ACE, 4'h5}), 32);
    e_test = 28'h1357ACE;
    chk("R1 strobe-high clocks ignored", 32'(test_cfg), 32'(e_test));

    // R4: control word clears the test field
    send(w_ctl(1'b1, 27'h0123456), 32);
    e_ctl = 27'h0123456; e_test = '0;
    chk_all("R4 test cleared");

    // R6: staging word has no visible effect yet
    send(w_stage(8'h5A, 2'd2), 32);
    t_cn = 8'h5A; t_pr = 2'd2;
    chk_all("R6 staged only");

    // R8/R10: long main word waits for sync
    send(w_main_l(20'h12345, 8'h3C), 32);
    chk("R10 speedup high", 32'(speedup), 32'd1);
    chk_all("R8 pending no sync");
    drop_strobe();
    chk("R10 speedup cleared", 32'(speedup), 32'd0);
    ser_strobe = 1'b1; waitc(10);
    chk("R10 no speedup without main word", 32'(speedup), 32'd0);

    // R7: short main word in long mode discarded
    send(w_main_s(20'hFFFFF), 24);
    chk("R7 short in long mode no speedup", 32'(speedup), 32'd0);

    // R9: newer long word replaces pending
    send(w_main_l(20'h0ABCD, 8'h77), 32);
    pulse_sync();
    e_div = 20'h0ABCD; e_cn = 8'h77; e_pr = t_pr;
    chk_all("R9 R8 commit long");

    // R8: sync with nothing pending
    pulse_sync();
    chk_all("R8 idle sync");

    // R7: short format; staged count taken at commit time
    send(w_ctl(1'b0, 27'h7000001), 32);
    e_long = 1'b0; e_ctl = 27'h7000001;
    send(w_main_s(20'h00F0F), 24);
    chk("R7 R10 short accepted speedup", 32'(speedup), 32'd1);
    send(w_stage(8'h11, 2'd1), 32);
    t_cn = 8'h11; t_pr = 2'd1;
    chk_all("R6 R8 before commit");
    pulse_sync();
    e_div = 20'h00F0F; e_cn = t_cn; e_pr = t_pr;
    chk_all("R7 R8 commit short");

    // R7: long word in short mode discarded
    send(w_main_l(20'hDEAD1, 8'hEE), 32);
    chk("R7 long in short mode no speedup", 32'(speedup), 32'd0);
    pulse_sync();
    chk_all("R7 long discarded");

    // R11: reset drops a pending word
    send(w_main_s(20'h55555), 24);
    rst_n = 1'b0;
    waitc(3);
    rst_n = 1'b1;
    waitc(10);
    clear_exp();
    chk_all("R11 reset regs");
    pulse_sync();
    chk_all("R11 pending cleared");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule